// File: doc/BRIEF.md
# Instruction Prefetch and Bus Sequencer

This block sits at the front of an 8-bit-data, 24-bit-address processor whose fetch, decode and execute stages overlap. It owns the single memory bus. In every cycle it decides whether the bus carries an instruction byte read, a data read or a data write. Execute-stage data accesses always get the bus. Instruction bytes are fetched, one per cycle, only in cycles the execute stage leaves free. As a result, how far fetching runs ahead depends on what the executing instruction does.

Fetched bytes go into a small prefetch buffer. The decoder supplies a combinational length (1 to 4 bytes) for the byte on the memory data input whenever that byte is an opcode. The block uses it to mark the first and last byte of each instruction as it arrives. Once an instruction is fully buffered, it presents the whole instruction, with its start address, to the decoder. A redirect (jump, call, return, restart or interrupt) throws away every buffered byte and fetching restarts at the target. If a data request arrives in the same cycle as a redirect, the data access is performed first and the flush takes effect in the next cycle.

Top module: `ifetch_sequencer`

## Requirements
- R1: While reset is held, `instValid` is low. The first bus cycle after reset is an instruction read (`busKind` 1) at address `RESET_PC` (default 0).
- R2: Consecutive instruction reads use consecutive addresses. The fetch address advances by one only on a completed instruction read.
- R3: When `exReq` is high, that cycle is a data cycle: `busKind` is 3 for a write and 2 for a read, `memAddr` equals `exAddr`, and `memWdata` equals `exWdata`. No instruction byte is read in that cycle, and fetching resumes at the next sequential address afterwards.
- R4: `fetchFirst` is high on an instruction read whose byte starts a new instruction. `fetchLast` is high on the read that completes an instruction of length `instLen`, which is the same read as the first one when the length is 1.
- R5: `instValid` rises in the cycle after the last byte of an instruction is read. `instBytes` then carries the opcode in bits 7:0, each following byte in the next higher 8 bits, and zeros beyond the instruction length. `instPc` gives the opcode's address.
- R6: The buffer holds 4 bytes. When it is full, the bus is idle (`busKind` 0) and `memAddr` holds the next fetch address, even in the cycle in which an instruction is consumed.
- R7: A redirect without `exReq` makes that cycle idle and discards every buffered byte. The next cycle reads from `redirectPc` with `fetchFirst` high and `instValid` low.
- R8: A redirect together with `exReq` performs the data access in that cycle. The next cycle reads the instruction at `redirectPc`.
- R9: While `instValid` is high and `decReady` is low, `instValid`, `instBytes` and `instPc` stay unchanged from cycle to cycle.
- R10: For the sequence increment, store-to-absolute-address, store-to-absolute-address, increment, with the execute stage writing in the cycle after each store is handed over, the address and cycle-kind trace matches the expected one exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| exReq | input | 1 | Execute stage requests a data bus cycle |
| exWrite | input | 1 | Data cycle is a write (1) or a read (0) |
| exAddr | input | 24 | Data access address |
| exWdata | input | 8 | Data write byte |
| redirect | input | 1 | Control transfer: flush and restart fetching |
| redirectPc | input | 24 | Control transfer target |
| memRdata | input | 8 | Memory read byte for the current cycle |
| instLen | input | 3 | Length of the opcode currently on memRdata (1..4) |
| decReady | input | 1 | Decoder accepts the presented instruction |
| memAddr | output | 24 | Bus address |
| memWdata | output | 8 | Bus write byte |
| busKind | output | 2 | 0 idle, 1 instruction read, 2 data read, 3 data write |
| fetchFirst | output | 1 | This instruction read fetches an opcode |
| fetchLast | output | 1 | This instruction read fetches the final byte of an instruction |
| instValid | output | 1 | A complete instruction is presented |
| instBytes | output | 32 | Instruction bytes, opcode in bits 7:0 |
| instPc | output | 24 | Address of the presented instruction |

## Verification
The bus outputs (`busKind`, `memAddr`, `memWdata`, `fetchFirst`, `fetchLast`) are combinational in the current request and state, so they are checked at the falling edge of the same cycle in which the request is driven. `instValid` and its contents are registered and appear one cycle after the final byte's read. Redirect and data-then-flush effects appear on the bus one cycle after the request. Inputs change just after a rising edge and every comparison is made at the following falling edge. The trace scoreboard pops one expected bus item per cycle from the first cycle after reset, and the execute model issues each store's write in the cycle after it sees that store handed over.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_INST = 2'd1,
    BUS_DRD  = 2'd2,
    BUS_DWR  = 2'd3
  } busKind_t;

  // Strobes from the sequencer control to the buffer datapath
  typedef struct packed {
    logic fetch;     // capture memRdata into the buffer
    logic flush;     // drop buffer, load redirect target
    logic pop;       // head instruction taken by decoder
    logic lastByte;  // captured byte ends an instruction
  } seqStrobe_t;

endpackage

// File: rtl/fetch_seq_ctrl.sv
module fetch_seq_ctrl
  import ifetch_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             exReq,
  input  logic             exWrite,
  input  logic             redirect,
  input  logic [CNT_W-1:0] instLen,
  input  logic [CNT_W-1:0] bufCount,
  input  logic             headReady,
  input  logic             decReady,
  output seqStrobe_t       strobe,
  output busKind_t         busKind,
  output logic             fetchFirst,
  output logic             fetchLast,
  output logic             instValid
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic [CNT_W-1:0] remain;  // bytes of the current instruction still to read
  logic             canFetch;

  always_comb begin
    canFetch   = !exReq && !redirect && (bufCount < FULL);
    if (exReq)         busKind = exWrite ? BUS_DWR : BUS_DRD;
    else if (canFetch) busKind = BUS_INST;
    else               busKind = BUS_IDLE;
    fetchFirst = canFetch && (remain == '0);
    fetchLast  = canFetch && ((remain == '0) ? (instLen <= ONE) : (remain == ONE));
    instValid  = headReady && !redirect;
    strobe.fetch    = canFetch;
    strobe.flush    = redirect;
    strobe.pop      = instValid && decReady;
    strobe.lastByte = fetchLast;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remain <= '0;
    end else if (redirect) begin
      remain <= '0;
    end else if (canFetch) begin
      if (remain == '0) remain <= (instLen <= ONE) ? '0 : instLen - ONE;
      else              remain <= remain - ONE;
    end
  end

endmodule

// File: rtl/fetch_buf_dp.sv
module fetch_buf_dp
  import ifetch_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [7:0]         memRdata,
  input  logic               exReq,
  input  logic [ADDR_W-1:0]  exAddr,
  input  logic [7:0]         exWdata,
  input  logic [ADDR_W-1:0]  redirectPc,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [7:0]         memWdata,
  output logic [CNT_W-1:0]   bufCount,
  output logic               headReady,
  output logic [8*DEPTH-1:0] instBytes,
  output logic [ADDR_W-1:0]  instPc
);

  logic [7:0]        slotByte [DEPTH];
  logic              slotLast [DEPTH];
  logic [7:0]        nByte    [DEPTH];
  logic              nLast    [DEPTH];
  logic [CNT_W-1:0]  count, nCount, headLen, shift;
  logic [ADDR_W-1:0] fetchPc, headPc;

  // Head instruction ends at the first marked slot
  always_comb begin
    headReady = 1'b0;
    headLen   = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < count) && slotLast[i]) begin
        headReady = 1'b1;
        headLen   = CNT_W'(i + 1);
      end
    end
    for (int i = 0; i < DEPTH; i++) begin
      instBytes[8*i +: 8] = (CNT_W'(i) < headLen) ? slotByte[i] : 8'h00;
    end
  end

  // Shift out the popped instruction, then append the fetched byte
  always_comb begin
    shift  = strobe.pop ? headLen : '0;
    nCount = count - shift;
    for (int i = 0; i < DEPTH; i++) begin
      nByte[i] = 8'h00;
      nLast[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j == i + int'(shift)) begin
          nByte[i] = slotByte[j];
          nLast[i] = slotLast[j];
        end
      end
    end
    if (strobe.fetch) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) == nCount) begin
          nByte[i] = memRdata;
          nLast[i] = strobe.lastByte;
        end
      end
      nCount = nCount + CNT_W'(1);
    end
    if (strobe.flush) begin
      nCount = '0;
      for (int i = 0; i < DEPTH; i++) nLast[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      fetchPc <= RESET_PC;
      headPc  <= RESET_PC;
      for (int i = 0; i < DEPTH; i++) begin
        slotByte[i] <= 8'h00;
        slotLast[i] <= 1'b0;
      end
    end else begin
      count    <= nCount;
      slotByte <= nByte;
      slotLast <= nLast;
      if (strobe.flush) begin
        fetchPc <= redirectPc;
        headPc  <= redirectPc;
      end else begin
        if (strobe.fetch) fetchPc <= fetchPc + ADDR_W'(1);
        if (strobe.pop)   headPc  <= headPc + ADDR_W'(headLen);
      end
    end
  end

  assign memAddr  = exReq ? exAddr : fetchPc;
  assign memWdata = exWdata;
  assign bufCount = count;
  assign instPc   = headPc;

endmodule

// File: rtl/ifetch_sequencer.sv
module ifetch_sequencer
  import ifetch_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         exReq,
  input  logic                         exWrite,
  input  logic [ADDR_W-1:0]            exAddr,
  input  logic [7:0]                   exWdata,
  input  logic                         redirect,
  input  logic [ADDR_W-1:0]            redirectPc,
  input  logic [7:0]                   memRdata,
  input  logic [$clog2(DEPTH+1)-1:0]   instLen,
  input  logic                         decReady,
  output logic [ADDR_W-1:0]            memAddr,
  output logic [7:0]                   memWdata,
  output logic [1:0]                   busKind,
  output logic                         fetchFirst,
  output logic                         fetchLast,
  output logic                         instValid,
  output logic [8*DEPTH-1:0]           instBytes,
  output logic [ADDR_W-1:0]            instPc
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  seqStrobe_t       strobe;
  busKind_t         kind;
  logic [CNT_W-1:0] bufCount;
  logic             headReady;

  fetch_seq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .exReq(exReq), .exWrite(exWrite),
    .redirect(redirect), .instLen(instLen), .bufCount(bufCount),
    .headReady(headReady), .decReady(decReady), .strobe(strobe),
    .busKind(kind), .fetchFirst(fetchFirst), .fetchLast(fetchLast),
    .instValid(instValid)
  );

  fetch_buf_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .memRdata(memRdata),
    .exReq(exReq), .exAddr(exAddr), .exWdata(exWdata),
    .redirectPc(redirectPc), .memAddr(memAddr), .memWdata(memWdata),
    .bufCount(bufCount), .headReady(headReady), .instBytes(instBytes),
    .instPc(instPc)
  );

  assign busKind = kind;

endmodule

// File: rtl/ifetch_sequencer_chk.sv
module ifetch_sequencer_chk #(
  parameter int DEPTH = 4,
  parameter int ADDR_W = 24,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               exReq,
  input logic               exWrite,
  input logic [ADDR_W-1:0]  exAddr,
  input logic               redirect,
  input logic [ADDR_W-1:0]  redirectPc,
  input logic               decReady,
  input logic [ADDR_W-1:0]  memAddr,
  input logic [1:0]         busKind,
  input logic               fetchFirst,
  input logic               fetchLast,
  input logic               instValid,
  input logic [8*DEPTH-1:0] instBytes,
  input logic [ADDR_W-1:0]  instPc,
  input logic [CNT_W-1:0]   bufCount
);

  logic              prevInst;
  logic [ADDR_W-1:0] prevAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevInst <= 1'b0;
      prevAddr <= '0;
    end else begin
      prevInst <= (busKind == 2'd1);
      prevAddr <= memAddr;
    end
  end

  a_r2_sequential_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (busKind == 2'd1 && prevInst) |-> memAddr == prevAddr + ADDR_W'(1));

  a_r3_data_owns_bus: assert property (@(posedge clk) disable iff (!rstN)
    exReq |-> (busKind == (exWrite ? 2'd3 : 2'd2)) && (memAddr == exAddr));

  a_r4_marks_on_fetch: assert property (@(posedge clk) disable iff (!rstN)
    (fetchFirst || fetchLast) |-> busKind == 2'd1);

  a_r6_no_fetch_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (bufCount == CNT_W'(DEPTH)) |-> busKind != 2'd1);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> !instValid);

  a_r8_target_next: assert property (@(posedge clk) disable iff (!rstN)
    redirect |=> (busKind != 2'd1) || (memAddr == $past(redirectPc)));

  a_r9_hold_when_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (instValid && !decReady && !redirect) |=>
      (redirect || (instValid && $stable(instBytes) && $stable(instPc))));

endmodule

bind ifetch_sequencer ifetch_sequencer_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .exReq(exReq), .exWrite(exWrite), .exAddr(exAddr),
  .redirect(redirect), .redirectPc(redirectPc), .decReady(decReady),
  .memAddr(memAddr), .busKind(busKind), .fetchFirst(fetchFirst),
  .fetchLast(fetchLast), .instValid(instValid), .instBytes(instBytes),
  .instPc(instPc), .bufCount(bufCount)
);

// File: tb/ifetch_sequencer_test.sv
module ifetch_sequencer_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic        exReq, exWrite, redirect, decReady;
  logic [23:0] exAddr, redirectPc, memAddr, instPc;
  logic [7:0]  exWdata, memRdata, memWdata;
  logic [2:0]  instLen;
  logic [1:0]  busKind;
  logic        fetchFirst, fetchLast, instValid;
  logic [31:0] instBytes;

  ifetch_sequencer uut (
    .clk(clk), .rstN(rstN), .exReq(exReq), .exWrite(exWrite), .exAddr(exAddr),
    .exWdata(exWdata), .redirect(redirect), .redirectPc(redirectPc),
    .memRdata(memRdata), .instLen(instLen), .decReady(decReady),
    .memAddr(memAddr), .memWdata(memWdata), .busKind(busKind),
    .fetchFirst(fetchFirst), .fetchLast(fetchLast), .instValid(instValid),
    .instBytes(instBytes), .instPc(instPc)
  );

  // Memory and length model
  function automatic logic [7:0] memByte(input logic [23:0] a);
    case (a)
      24'd0: memByte = 8'h3C;  24'd1: memByte = 8'h32;
      24'd2: memByte = 8'h34;  24'd3: memByte = 8'h12;
      24'd4: memByte = 8'h32;  24'd5: memByte = 8'h78;
      24'd6: memByte = 8'h56;  24'd7: memByte = 8'h3C;
      default: memByte = a[7:0];
    endcase
  endfunction

  function automatic logic [2:0] lenOf(input logic [7:0] op);
    if (op == 8'h3C)      lenOf = 3'd1;
    else if (op == 8'h32) lenOf = 3'd3;
    else                  lenOf = {1'b0, op[1:0]} + 3'd1;
  endfunction

  assign memRdata = memByte(memAddr);
  assign instLen  = lenOf(memRdata);

  // Execute model: a store handed over issues its write in the next cycle
  logic        autoExec, storeNext, storeAct;
  logic [23:0] storeNextAddr, storeAddr;
  logic        manReq, manWrite;
  logic [23:0] manAddr;
  logic [7:0]  manWdata;

  assign exReq   = storeAct | manReq;
  assign exWrite = storeAct ? 1'b1 : manWrite;
  assign exAddr  = storeAct ? storeAddr : manAddr;
  assign exWdata = storeAct ? 8'h5A : manWdata;

  always @(negedge clk) begin
    storeNext     = autoExec && rstN && instValid && decReady && (instBytes[7:0] == 8'h32);
    storeNextAddr = {8'h00, instBytes[23:16], instBytes[15:8]};
  end
  always @(posedge clk) begin
    #1;
    storeAct  = storeNext;
    storeAddr = storeNextAddr;
  end

  // Scoreboard
  typedef struct {
    logic [1:0]  kind;
    logic [23:0] addr;
    logic        first;
    logic        last;
    string       tag;
  } busItem_t;
  typedef struct {
    logic [23:0] pc;
    logic [31:0] bytes;
  } instItem_t;

  busItem_t  busQ[$];
  instItem_t instQ[$];
  logic      monOn;
  int        nChecks = 0;
  int        nFail = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushBus(input logic [1:0] k, input logic [23:0] a,
                         input logic f, input logic l, input string tag);
    busItem_t e;
    e.kind = k; e.addr = a; e.first = f; e.last = l; e.tag = tag;
    busQ.push_back(e);
  endtask

  task automatic pushInst(input logic [23:0] pc, input logic [31:0] b);
    instItem_t e;
    e.pc = pc; e.bytes = b;
    instQ.push_back(e);
  endtask

  always @(negedge clk) begin
    busItem_t  be;
    instItem_t ie;
    if (rstN && monOn) begin
      if (busQ.size() > 0) begin
        be = busQ.pop_front();
        check({busKind, memAddr, fetchFirst, fetchLast} == {be.kind, be.addr, be.first, be.last},
              be.tag, {4'h0, busKind, memAddr, fetchFirst, fetchLast},
              {4'h0, be.kind, be.addr, be.first, be.last});
      end
      if (instValid && decReady && instQ.size() > 0) begin
        ie = instQ.pop_front();
        check(instPc == ie.pc, "R5 pc", {8'h00, instPc}, {8'h00, ie.pc});
        check(instBytes == ie.bytes, "R5 bytes", instBytes, ie.bytes);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic smp();
    @(negedge clk);
  endtask

  task automatic finishUp();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishUp();
  end

  initial begin
    redirect = 1'b0; redirectPc = '0; decReady = 1'b1; autoExec = 1'b1;
    manReq = 1'b0; manWrite = 1'b0; manAddr = '0; manWdata = '0;
    storeNext = 1'b0; storeAct = 1'b0; storeNextAddr = '0; storeAddr = '0;
    monOn = 1'b0;
    repeat (3) @(posedge clk);
    smp();
    check(!instValid, "R1 no instruction in reset", {31'h0, instValid}, 32'h0);

    // R10 trace: INC, LD (1234h),A, LD (5678h),A, INC
    pushBus(2'd1, 24'h000000, 1, 1, "R1 first fetch");
    pushBus(2'd1, 24'h000001, 1, 0, "R10");
    pushBus(2'd1, 24'h000002, 0, 0, "R10");
    pushBus(2'd1, 24'h000003, 0, 1, "R10");
    pushBus(2'd1, 24'h000004, 1, 0, "R10");
    pushBus(2'd3, 24'h001234, 0, 0, "R3 store write");
    pushBus(2'd1, 24'h000005, 0, 0, "R10");
    pushBus(2'd1, 24'h000006, 0, 1, "R10");
    pushBus(2'd1, 24'h000007, 1, 1, "R10");
    pushBus(2'd3, 24'h005678, 0, 0, "R3 store write");
    pushBus(2'd1, 24'h000008, 1, 1, "R10");
    pushInst(24'h000000, 32'h0000003C);
    pushInst(24'h000001, 32'h00123432);
    pushInst(24'h000004, 32'h00567832);
    pushInst(24'h000007, 32'h0000003C);
    monOn = 1'b1;
    step();
    rstN = 1'b1;
    repeat (11) smp();
    #2;
    monOn = 1'b0;
    autoExec = 1'b0;
    check(busQ.size() == 0 && instQ.size() == 0, "R10 all items seen",
          busQ.size() + instQ.size(), 32'h0);

    // Redirect to 0x43 (length 4) with the decoder stalled: fill the buffer
    step(); decReady = 1'b0; redirect = 1'b1; redirectPc = 24'h000043;
    smp();
    check(busKind == 2'd0, "R7 redirect cycle idle", {30'h0, busKind}, 32'h0);
    step(); redirect = 1'b0;
    for (int i = 0; i < 4; i++) begin
      smp();
      check(busKind == 2'd1 && memAddr == 24'h43 + 24'(i), "R2 sequential fetch",
            {6'h0, busKind, memAddr}, {6'h0, 2'd1, 24'h43 + 24'(i)});
      if (i == 0) check(fetchFirst, "R4 first byte marked", {31'h0, fetchFirst}, 32'h1);
      if (i == 3) check(fetchLast, "R4 last byte marked", {31'h0, fetchLast}, 32'h1);
      step();
    end
    smp();
    check(busKind == 2'd0 && memAddr == 24'h47, "R6 full buffer idles",
          {6'h0, busKind, memAddr}, {6'h0, 2'd0, 24'h47});
    check(instValid && instBytes == 32'h46454443, "R5 four-byte instruction",
          instBytes, 32'h46454443);
    check(instPc == 24'h43, "R5 instruction address", {8'h0, instPc}, 32'h43);
    repeat (3) begin
      step(); smp();
      check(instValid && instBytes == 32'h46454443 && instPc == 24'h43,
            "R9 held while stalled", instBytes, 32'h46454443);
    end
    step(); decReady = 1'b1;
    smp();
    check(busKind == 2'd0, "R6 no fetch in consume cycle", {30'h0, busKind}, 32'h0);
    step(); smp();
    check(busKind == 2'd1 && memAddr == 24'h47, "R2 fetch resumes",
          {6'h0, busKind, memAddr}, {6'h0, 2'd1, 24'h47});
    check(!instValid, "R5 buffer drained", {31'h0, instValid}, 32'h0);

    // Jump in mid-instruction: buffered bytes are dropped
    step(); decReady = 1'b0;
    smp();
    check(busKind == 2'd1 && memAddr == 24'h48, "R2 second byte",
          {6'h0, busKind, memAddr}, {6'h0, 2'd1, 24'h48});
    step(); redirect = 1'b1; redirectPc = 24'h000080;
    smp();
    check(busKind == 2'd0, "R7 jump cycle idle", {30'h0, busKind}, 32'h0);
    step(); redirect = 1'b0;
    smp();
    check(busKind == 2'd1 && memAddr == 24'h80 && fetchFirst && !instValid,
          "R7 restart at target", {5'h0, instValid, busKind, memAddr},
          {5'h0, 1'b0, 2'd1, 24'h80});
    step(); smp();
    check(instValid && instPc == 24'h80 && instBytes == 32'h00000080,
          "R7 only target bytes emitted", instBytes, 32'h00000080);

    // Redirect together with a data write
    step(); decReady = 1'b1; redirect = 1'b1; redirectPc = 24'h0000C1;
    manReq = 1'b1; manWrite = 1'b1; manAddr = 24'h123456; manWdata = 8'h99;
    smp();
    check(busKind == 2'd3 && memAddr == 24'h123456 && memWdata == 8'h99,
          "R8 data write before flush", {busKind, memAddr, memWdata[5:0]},
          {2'd3, 24'h123456, 6'h19});
    step(); redirect = 1'b0; manReq = 1'b0;
    smp();
    check(busKind == 2'd1 && memAddr == 24'hC1, "R8 target fetched next",
          {6'h0, busKind, memAddr}, {6'h0, 2'd1, 24'hC1});

    // Data read steals one cycle, then fetching resumes sequentially
    step(); manReq = 1'b1; manWrite = 1'b0; manAddr = 24'h222222;
    smp();
    check(busKind == 2'd2 && memAddr == 24'h222222, "R3 data read",
          {6'h0, busKind, memAddr}, {6'h0, 2'd2, 24'h222222});
    step(); manReq = 1'b0;
    smp();
    check(busKind == 2'd1 && memAddr == 24'hC2 && fetchLast, "R3 resume after read",
          {5'h0, fetchLast, busKind, memAddr}, {5'h0, 1'b1, 2'd1, 24'hC2});
    step();
    finishUp();
  end

endmodule